// File: doc/BRIEF.md
# No-Data-Retry Bus Protocol Checker

This block is a passive monitor placed beside a bus interface. It watches the hard reset line, the data-retry and address-retry lines, transfer acknowledge, and a marker that flags the start of each data tenure. It drives nothing onto the bus. Its only job is to report cancellations that the selected bus mode forbids.

The block takes the operating mode from a strap. While hard reset is held, it samples the data-retry line. The level seen in the last reset cycle becomes the mode until the next reset.

- With the strap low, the bus runs in normal mode. Data may be cancelled in the cycle after an acknowledge, either by data retry or by address retry, and the monitor stays silent.
- With the strap high, the bus runs in no-data-retry mode. Any data retry is an error. An address retry is an error when it arrives in the cycle right after the first acknowledge of a tenure. Address retries on or before that acknowledge are legal.
- Errors are held in sticky flags. A 2-bit code gives the type of the latest violation, and a one-cycle pulse marks each violating cycle.

Top module: `ndrProtoChk`

## Requirements
- R1: The mode is the level of `dataRetry` in the last clock cycle in which `hardRst` is high. It does not change while `hardRst` is low.
- R2: In normal mode (strap low), `dataRetry` never sets `drErr`, `errCode` or `errPulse`.
- R3: In normal mode, `addrRetry` in any cycle, including the cycle after an acknowledge, never sets `arErr`, `errCode` or `errPulse`.
- R4: In no-data-retry mode, `dataRetry` high in any cycle with `hardRst` low sets `drErr` on the next clock edge, raises `errPulse` for that one cycle, and sets bit 0 of `errCode`.
- R5: In no-data-retry mode, `addrRetry` on or before the cycle of the first `xferAck` of a tenure is not flagged.
- R6: In no-data-retry mode, `addrRetry` in the cycle right after the first `xferAck` of a tenure sets `arErr` on the next edge, pulses `errPulse`, and sets bit 1 of `errCode`.
- R7: The first acknowledge is tracked per tenure. `tenureStart` re-arms the tracking, so the first acknowledge of every new tenure opens a new late window. Later acknowledges in the same tenure open no window, and `addrRetry` after them is not flagged.
- R8: `drErr` and `arErr` stay high until `hardRst` is asserted.
- R9: On each violating cycle, `errCode` loads {late address retry, data retry}, so both at once give 2'b11. It holds that value until the next violation. `errPulse` is high only in the cycle after a violating cycle. `errCode` reads 2'b00 until the first violation.
- R10: While `hardRst` is high, all outputs are low, and the bus inputs other than the strap sample have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| hardRst | input | 1 | Hard reset, active high. It also clears the monitor. |
| dataRetry | input | 1 | Data-retry line, active high. It is also the mode strap during reset. |
| addrRetry | input | 1 | Address-retry line, active high |
| xferAck | input | 1 | Transfer acknowledge, active high |
| tenureStart | input | 1 | High in the first cycle of a data tenure |
| drErr | output | 1 | Sticky flag for a data-retry violation |
| arErr | output | 1 | Sticky flag for a late address-retry violation |
| errCode | output | 2 | Type of the latest violation: bit0 = data retry, bit1 = late address retry |
| errPulse | output | 1 | One-cycle strobe for each violating cycle |

## Verification
A wrong latched mode shows on the first retry after reset. Either `errPulse` fires in normal mode, or it stays low on a forbidden data retry, one edge after the retry.

A wrong first-acknowledge flag moves the late window. A stale flag that survives a tenure start, or a flag set by a later beat, makes a legal address retry fire, or lets a forbidden one pass, one edge after the retry cycle. The sweep places the retry at every cycle of a two-tenure pattern, so such a fault shows up in that same cycle.

// File: rtl/ndrChkPkg.sv
package ndrChkPkg;

  typedef enum logic [1:0] {
    ERR_NONE = 2'b00,
    ERR_DATA = 2'b01,
    ERR_ADDR = 2'b10,
    ERR_BOTH = 2'b11
  } errCodeT;

  // strobes from control to the error datapath
  typedef struct packed {
    logic arViol;
    logic drViol;
  } ctrlStrobeT;

endpackage

// File: rtl/ndrCtrl.sv
module ndrCtrl
  import ndrChkPkg::*;
(
  input  logic       clk,
  input  logic       hardRst,
  input  logic       dataRetry,
  input  logic       addrRetry,
  input  logic       xferAck,
  input  logic       tenureStart,
  output ctrlStrobeT strobe,
  output logic       noDrMode
);

  logic modeReg;
  logic firstSeen;
  logic firstAckDly;
  logic seenLive;
  logic firstAckNow;

  // a tenure start forgets the previous tenure's acknowledge
  assign seenLive    = firstSeen & ~tenureStart;
  assign firstAckNow = xferAck & ~seenLive;

  always_ff @(posedge clk) begin
    if (hardRst) begin
      modeReg     <= dataRetry;  // strap sample
      firstSeen   <= 1'b0;
      firstAckDly <= 1'b0;
    end else begin
      firstSeen   <= seenLive | xferAck;
      firstAckDly <= firstAckNow;
    end
  end

  always_comb begin
    strobe.drViol = ~hardRst & modeReg & dataRetry;
    strobe.arViol = ~hardRst & modeReg & addrRetry & firstAckDly;
  end

  assign noDrMode = modeReg;

endmodule

// File: rtl/ndrErrPath.sv
module ndrErrPath
  import ndrChkPkg::*;
(
  input  logic       clk,
  input  logic       hardRst,
  input  ctrlStrobeT strobe,
  output logic       drErr,
  output logic       arErr,
  output errCodeT    errCode,
  output logic       errPulse
);

  logic anyViol;
  assign anyViol = strobe.drViol | strobe.arViol;

  always_ff @(posedge clk) begin
    if (hardRst) begin
      drErr    <= 1'b0;
      arErr    <= 1'b0;
      errCode  <= ERR_NONE;
      errPulse <= 1'b0;
    end else begin
      drErr    <= drErr | strobe.drViol;
      arErr    <= arErr | strobe.arViol;
      errPulse <= anyViol;
      if (anyViol) errCode <= errCodeT'({strobe.arViol, strobe.drViol});
    end
  end

endmodule

// File: rtl/ndrProtoChk.sv
module ndrProtoChk
  import ndrChkPkg::*;
(
  input  logic       clk,
  input  logic       hardRst,
  input  logic       dataRetry,
  input  logic       addrRetry,
  input  logic       xferAck,
  input  logic       tenureStart,
  output logic       drErr,
  output logic       arErr,
  output logic [1:0] errCode,
  output logic       errPulse
);

  ctrlStrobeT strobe;
  errCodeT    codeInt;
  logic       noDrMode;

  ndrCtrl u_ctrl (
    .clk         (clk),
    .hardRst     (hardRst),
    .dataRetry   (dataRetry),
    .addrRetry   (addrRetry),
    .xferAck     (xferAck),
    .tenureStart (tenureStart),
    .strobe      (strobe),
    .noDrMode    (noDrMode)
  );

  ndrErrPath u_err (
    .clk      (clk),
    .hardRst  (hardRst),
    .strobe   (strobe),
    .drErr    (drErr),
    .arErr    (arErr),
    .errCode  (codeInt),
    .errPulse (errPulse)
  );

  assign errCode = codeInt;

endmodule

// File: rtl/ndrProtoChkSva.sv
module ndrProtoChkSva (
  input logic       clk,
  input logic       hardRst,
  input logic       dataRetry,
  input logic       noDrMode,
  input logic       drErr,
  input logic       arErr,
  input logic [1:0] errCode,
  input logic       errPulse
);

  // R1
  mode_hold_chk: assert property (@(posedge clk) disable iff (hardRst)
    1'b1 |=> $stable(noDrMode));

  // R2
  normal_quiet_chk: assert property (@(posedge clk) disable iff (hardRst)
    !noDrMode |-> (!drErr && !arErr && !errPulse));

  // R4
  dr_flag_chk: assert property (@(posedge clk) disable iff (hardRst)
    (noDrMode && dataRetry) |=> (drErr && errPulse && errCode[0]));

  // R8
  dr_sticky_chk: assert property (@(posedge clk) disable iff (hardRst)
    drErr |=> drErr);

  // R8
  ar_sticky_chk: assert property (@(posedge clk) disable iff (hardRst)
    arErr |=> arErr);

  // R9
  pulse_code_chk: assert property (@(posedge clk) disable iff (hardRst)
    errPulse |-> (errCode != 2'b00));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    hardRst |=> (!drErr && !arErr && !errPulse && errCode == 2'b00));

endmodule

bind ndrProtoChk ndrProtoChkSva u_sva (
  .clk       (clk),
  .hardRst   (hardRst),
  .dataRetry (dataRetry),
  .noDrMode  (noDrMode),
  .drErr     (drErr),
  .arErr     (arErr),
  .errCode   (errCode),
  .errPulse  (errPulse)
);

// File: tb/tb_ndrProtoChk.sv
`timescale 1ns/1ps
module tb_ndrProtoChk;

  logic       clk = 1'b0;
  logic       hardRst = 1'b1;
  logic       dataRetry = 1'b0;
  logic       addrRetry = 1'b0;
  logic       xferAck = 1'b0;
  logic       tenureStart = 1'b0;
  logic       drErr, arErr, errPulse;
  logic [1:0] errCode;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  ndrProtoChk dut (
    .clk(clk), .hardRst(hardRst), .dataRetry(dataRetry), .addrRetry(addrRetry),
    .xferAck(xferAck), .tenureStart(tenureStart),
    .drErr(drErr), .arErr(arErr), .errCode(errCode), .errPulse(errPulse)
  );

  task automatic checkOut(string tag, logic eDr, logic eAr, logic [1:0] eCode, logic ePulse);
    checks++;
    if ({drErr, arErr, errCode, errPulse} !== {eDr, eAr, eCode, ePulse}) begin
      errors++;
      $display("FAIL %s at %0t: got dr=%b ar=%b code=%b pulse=%b, expected dr=%b ar=%b code=%b pulse=%b",
               tag, $time, drErr, arErr, errCode, errPulse, eDr, eAr, eCode, ePulse);
    end
  endtask

  // hold reset with junk on the bus; the last reset cycle carries the strap
  task automatic doReset(bit strap);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      hardRst     = 1'b1;
      dataRetry   = (i == 3) ? strap : ~strap;
      addrRetry   = i[0];
      xferAck     = 1'b1;
      tenureStart = i[1];
      @(posedge clk); #1;
      checkOut("R10", 1'b0, 1'b0, 2'b00, 1'b0);
    end
  endtask

  // two tenures: starts at 0 and 6, acks at 2,3 and 7; late cycles 3 and 8
  task automatic runScenario(bit mode, int arPos, int drPos);
    logic eDr = 1'b0, eAr = 1'b0;
    logic [1:0] eCode = 2'b00;
    string tag;
    if (!mode) tag = "R1 R2 R3";
    else if (arPos >= 0) tag = "R1 R4 R5 R6 R7 R8 R9";
    else tag = "R1 R4 R8 R9";
    doReset(mode);
    for (int c = 0; c < 10; c++) begin
      logic vAr, vDr, ePulse;
      @(negedge clk);
      hardRst     = 1'b0;
      tenureStart = (c == 0 || c == 6);
      xferAck     = (c == 2 || c == 3 || c == 7);
      addrRetry   = (c == arPos);
      dataRetry   = (c == drPos);
      @(posedge clk); #1;
      vAr = mode && (c == arPos) && (c == 3 || c == 8);
      vDr = mode && (c == drPos);
      ePulse = vAr | vDr;
      if (ePulse) eCode = {vAr, vDr};
      eDr = eDr | vDr;
      eAr = eAr | vAr;
      checkOut(tag, eDr, eAr, eCode, ePulse);
    end
    // idle tail: flags must stay set (R8) with no pulse
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      tenureStart = 1'b0; xferAck = 1'b0; addrRetry = 1'b0; dataRetry = 1'b0;
      @(posedge clk); #1;
      checkOut("R8 R9", eDr, eAr, eCode, 1'b0);
    end
  endtask

  initial begin
    for (int m = 0; m < 2; m++)
      for (int a = -1; a < 10; a++)
        for (int d = -1; d < 10; d++)
          runScenario(m[0], a, d);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got no completion, expected end of sweep");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule